// File: doc/BRIEF.md
# Fractional M/N Clock Divider

This block turns a source clock into a slower output by two stages. The first stage is an integer pre-divider that produces one enable tick every (field + 1) source cycles. The second stage is a fractional rate counter. It adds M to an accumulator on each tick and subtracts N whenever the sum reaches N. The output therefore carries M pulses for every N ticks, so the average output rate is the source rate divided by the pre-divide ratio and then scaled by M/N. A level output rises on each counter overflow and falls at a programmable duty point, which gives a clock-like waveform.

Control arrives as two static words. The divider word carries the source selection, the pre-divide value, the complemented (N - M) value, the counter mode, the counter enable and a counter-reset bit. The multiplier word carries M and the complemented duty term. Software raises counter reset, rewrites the fields and then drops counter reset. The counter then restarts from zero. When the counter is disabled or N is zero, the output is simply the pre-divided tick. The source selection field is decoded and passed on to an external clock multiplexer.

Top module: `mnd_frac_div`

## Requirements
- R1: With the counter inactive (enable bit 0, mode field 00, or recovered N equal to 0), `pulse_o` and `level_o` are high in exactly one of every (P + 1) cycles, where P is the pre-divide field. P ranges over 0 to 2^PW - 1.
- R2: With the counter active (enable bit 1, mode field non-zero, recovered N non-zero, M <= N), the first k pre-divide ticks after counter reset is released produce exactly floor(k*M/N) cycles with `pulse_o` high. When M equals N, every tick produces a pulse.
- R3: Divider word layout for the default parameters: bits [2:0] source select, bits [5:3] pre-divide P, bits [13:6] the complement of (N - M) truncated to 8 bits, bits [15:14] mode (10 = dual-edge, 00 = counter off), bit 16 counter enable, bit 17 counter reset. N is recovered as (that field inverted) + M, modulo 2^8.
- R4: Multiplier word layout: bits [7:0] hold the complement of the duty term D, and M sits at bit offset M_SHIFT (bits [15:8] by default). Programming N = 0 is written as all of M, duty, (N - M), mode and enable set to zero.
- R5: While the counter-reset bit is 1, `pulse_o` and `level_o` stay 0 whatever M, N or P hold, and the pre-divider and accumulator are held at zero.
- R6: After counter reset is released with P = 0, M = 1 and N = 4, the first pulse appears on the 4th cycle. This is one full output period after release.
- R7: In counter mode, `level_o` rises on a tick that overflows. It falls on a non-overflowing tick whose new accumulator value is at least D/2. When both conditions hold on the same tick, the overflow wins and the level goes or stays high.
- R8: `src_sel_o` always equals the source-select field of the divider word.
- R9: While `rst_n` is low, `pulse_o` and `level_o` are 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ns_i | input | SW+PW+CW+4 (18) | Divider control word |
| md_i | input | M_SHIFT+CW (16) | Multiplier and duty control word |
| src_sel_o | output | SW (3) | Decoded source select for the external multiplexer |
| pulse_o | output | 1 | One-cycle pulse per output period |
| level_o | output | 1 | Output clock level with programmed duty |

## Verification
An overflow and a duty-threshold fall can arrive on the same pre-divide tick. The bench provokes this with M = 3, N = 4 and D = 4. In that setting the accumulator already sits at or above D/2 when it wraps on the second tick. The bench expects the level to stay high through ticks 2 to 4 and to drop only on tick 5. A design that let the fall win would show the level low on the second sample. Counter reset held together with live field changes is the other overlap. There the bench expects no pulse at all across the window.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_DUAL = 2'b10;
endpackage

// File: rtl/mnd_field_dec.sv
module mnd_field_dec #(
    parameter int SW      = 3,
    parameter int PW      = 3,
    parameter int CW      = 8,
    parameter int M_SHIFT = 8,
    localparam int NSW    = SW + PW + CW + 4,
    localparam int MDW    = M_SHIFT + CW
) (
    input  logic [NSW-1:0] ns_i,
    input  logic [MDW-1:0] md_i,
    output logic [SW-1:0]  src_o,
    output logic [PW-1:0]  pdiv_o,
    output logic [CW-1:0]  m_o,
    output logic [CW-1:0]  n_o,
    output logic [CW-1:0]  half_o,
    output logic           active_o,
    output logic           crst_o
);
    import mnd_pkg::*;

    localparam int P_LO   = SW;
    localparam int NM_LO  = SW + PW;
    localparam int MOD_LO = SW + PW + CW;
    localparam int EN_BIT = MOD_LO + 2;
    localparam int RS_BIT = MOD_LO + 3;

    logic [CW-1:0] nm_inv;
    logic [CW-1:0] duty;
    logic [1:0]    mode;

    always_comb begin
        src_o    = ns_i[SW-1:0];
        pdiv_o   = ns_i[P_LO +: PW];
        nm_inv   = ns_i[NM_LO +: CW];
        mode     = ns_i[MOD_LO +: 2];
        crst_o   = ns_i[RS_BIT];
        m_o      = md_i[M_SHIFT +: CW];
        n_o      = (~nm_inv) + m_o;
        duty     = ~md_i[CW-1:0];
        half_o   = duty >> 1;
        active_o = ns_i[EN_BIT] && (mode != MODE_OFF) && (n_o != '0);
    end
endmodule

// File: rtl/mnd_prediv.sv
module mnd_prediv #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crst_i,
    input  logic [PW-1:0] pdiv_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pd_state_t;

    pd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = !crst_i && (st_q.cnt >= pdiv_i);
        if (crst_i || tick_o) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crst_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crst_i,
    input  logic          active_i,
    input  logic          tick_i,
    input  logic [CW-1:0] m_i,
    input  logic [CW-1:0] n_i,
    input  logic [CW-1:0] half_i,
    output logic          pulse_o,
    output logic          level_o
);
    typedef struct packed {
        logic [CW-1:0] acc;
        logic          pulse;
        logic          level;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [CW:0] sum;
    logic        wrap;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, m_i};
        wrap = sum >= {1'b0, n_i};
        if (crst_i) begin
            st_d = '0;
        end else if (!active_i) begin
            st_d.acc   = '0;
            st_d.pulse = tick_i;
            st_d.level = tick_i;
        end else if (tick_i) begin
            if (wrap) begin
                st_d.acc   = sum[CW-1:0] - n_i;
                st_d.pulse = 1'b1;
                st_d.level = 1'b1;
            end else begin
                st_d.acc   = sum[CW-1:0];
                st_d.pulse = 1'b0;
                if (sum >= {1'b0, half_i}) st_d.level = 1'b0;
            end
        end else begin
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign level_o = st_q.level;

    // R5
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crst_i |=> (!st_q.pulse && !st_q.level));
    // R2
    pulse_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !st_q.pulse);
    // R7
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.level) |-> st_q.pulse);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !crst_i && (m_i <= n_i)) |-> (st_q.acc < n_i));
endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div #(
    parameter int SW      = 3,
    parameter int PW      = 3,
    parameter int CW      = 8,
    parameter int M_SHIFT = 8,
    localparam int NSW    = SW + PW + CW + 4,
    localparam int MDW    = M_SHIFT + CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NSW-1:0] ns_i,
    input  logic [MDW-1:0] md_i,
    output logic [SW-1:0]  src_sel_o,
    output logic           pulse_o,
    output logic           level_o
);
    logic [PW-1:0] pdiv;
    logic [CW-1:0] m_val, n_val, half_val;
    logic          active, crst, tick;

    mnd_field_dec #(.SW(SW), .PW(PW), .CW(CW), .M_SHIFT(M_SHIFT)) dec_i (
        .ns_i     (ns_i),
        .md_i     (md_i),
        .src_o    (src_sel_o),
        .pdiv_o   (pdiv),
        .m_o      (m_val),
        .n_o      (n_val),
        .half_o   (half_val),
        .active_o (active),
        .crst_o   (crst)
    );

    mnd_prediv #(.PW(PW)) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .crst_i (crst),
        .pdiv_i (pdiv),
        .tick_o (tick)
    );

    mnd_accum #(.CW(CW)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .crst_i   (crst),
        .active_i (active),
        .tick_i   (tick),
        .m_i      (m_val),
        .n_i      (n_val),
        .half_i   (half_val),
        .pulse_o  (pulse_o),
        .level_o  (level_o)
    );

    // R9
    rst_out_chk: assert property (@(posedge clk)
        !rst_n |-> (!pulse_o && !level_o));
endmodule

// File: tb/mnd_frac_div_tb.sv
module mnd_frac_div_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] ns_w = '0;
    logic [15:0] md_w = '0;
    logic [2:0]  src_sel;
    logic        pulse, level;

    int n_tests = 0;
    int n_fail  = 0;
    int cnt_p;
    logic pl [1:8];
    logic lv [1:8];

    always #5 clk = ~clk;

    mnd_frac_div dut_i (
        .clk(clk), .rst_n(rst_n), .ns_i(ns_w), .md_i(md_w),
        .src_sel_o(src_sel), .pulse_o(pulse), .level_o(level)
    );

    // columns: P, M, N, mode, en, window, expected pulse cycles
    localparam int VEC [0:9][0:6] = '{
        '{0, 1, 4, 2, 1, 400, 100},
        '{0, 3, 4, 2, 1, 400, 300},
        '{1, 1, 3, 2, 1, 300,  50},
        '{2, 2, 5, 2, 1, 300,  40},
        '{7, 1, 1, 2, 1, 400,  50},
        '{0, 0, 0, 0, 0, 100, 100},
        '{3, 0, 0, 0, 0, 400, 100},
        '{0, 5, 7, 2, 0,  70,  70},
        '{0, 5, 7, 0, 1,  70,  70},
        '{0, 5, 7, 2, 1, 700, 500}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic program_words(input int p, input int m, input int n, input int mode,
                                 input int en, input int src, input int d, input bit crst);
        logic [7:0] nm, dinv, mm;
        if (n == 0) begin
            nm = '0; dinv = '0; mm = '0;
        end else begin
            nm = ~8'(n - m); dinv = ~8'(d); mm = 8'(m);
        end
        ns_w = {crst, 1'(en), 2'(mode), nm, 3'(p), 3'(src)};
        md_w = {mm, dinv};
    endtask

    task automatic run_window(input int w);
        cnt_p = 0;
        for (int i = 1; i <= w; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pulse) cnt_p++;
            if (i <= 8) begin
                pl[i] = pulse;
                lv[i] = level;
            end
        end
    endtask

    task automatic start(input int p, input int m, input int n, input int mode,
                         input int en, input int d);
        @(negedge clk);
        program_words(p, m, n, mode, en, 0, d, 1'b1);
        repeat (3) @(negedge clk);
        program_words(p, m, n, mode, en, 0, d, 1'b0);
    endtask

    initial begin
        #1500000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R9 reset state
        program_words(0, 1, 4, 2, 1, 5, 4, 1'b0);
        repeat (3) @(negedge clk);
        check("R9 pulse in reset", pulse, 0);
        check("R9 level in reset", level, 0);
        // R8
        check("R8 src select", src_sel, 5);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 rate table
        for (int v = 0; v < 10; v++) begin
            start(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][2]);
            run_window(VEC[v][5]);
            check((VEC[v][4] == 1 && VEC[v][3] != 0 && VEC[v][2] != 0) ?
                  "R2 counter rate" : "R1 bypass rate", cnt_p, VEC[v][6]);
        end

        // R6 first pulse one period after release, R7 duty shape
        start(0, 1, 4, 2, 1, 4);
        run_window(8);
        check("R6 sample1", pl[1], 0);
        check("R6 sample3", pl[3], 0);
        check("R6 sample4", pl[4], 1);
        check("R6 sample8", pl[8], 1);
        begin
            logic exp_l [1:8] = '{0, 0, 0, 1, 1, 0, 0, 1};
            for (int i = 1; i <= 8; i++) check("R7 level duty", lv[i], exp_l[i]);
        end

        // R7 overflow and duty fall on the same tick: overflow wins
        start(0, 3, 4, 2, 1, 4);
        run_window(5);
        begin
            logic exp_c [1:5] = '{0, 1, 1, 1, 0};
            for (int i = 1; i <= 5; i++) check("R7 overflow priority", lv[i], exp_c[i]);
        end

        // R5 held in counter reset while fields change
        @(negedge clk);
        program_words(0, 1, 1, 2, 1, 2, 1, 1'b1);
        cnt_p = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 20) program_words(0, 1, 0, 0, 0, 2, 0, 1'b1);
            if (pulse || level) cnt_p++;
        end
        check("R5 hold in counter reset", cnt_p, 0);
        check("R8 src select live", src_sel, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule